// File: doc/BRIEF.md
# Delay Slew Rate Limiter

This block keeps a fixed-point "current delay" register that follows a requested delay target in small steps. Each time the sample strobe fires, the block compares the full requested value, fraction bits included, with the current value. It then moves the current value one fixed step toward the target, or leaves it unchanged if the two are equal. The steps are not symmetric. A rising delay grows by a larger fractional increment than the amount a falling delay shrinks by. A sudden change in the requested delay therefore becomes a smooth glide, and the read position of a delay line no longer jumps in a way that can be heard.

The value has `INT_W` integer bits and `FRAC_W` fraction bits. All arithmetic wraps modulo 2^(INT_W+FRAC_W), so the integer part always stays inside the range of the delay buffer. The block registers the integer part separately, and the read-address generator subtracts that integer part from the write pointer.

Top module: `dly_slew_lim`

## Requirements
- R1: While reset is high and in the cycle after it falls, `delay_full` equals `RST_INT` shifted left by `FRAC_W` (integer 1, fraction 0 by default) and `delay_int` equals `RST_INT`.
- R2: A clock edge on which `tick` is low leaves `delay_full` and `delay_int` unchanged, whatever the value of `desired`.
- R3: On a `tick` edge where `desired` equals `delay_full` exactly, both outputs stay unchanged.
- R4: On a `tick` edge where `desired` is greater than `delay_full` (unsigned, full width), `delay_full` becomes `delay_full + UP_STEP` (default 4) modulo 2^(INT_W+FRAC_W).
- R5: On a `tick` edge where `desired` is less than `delay_full`, `delay_full` becomes `delay_full - DN_STEP` (default 2) modulo 2^(INT_W+FRAC_W).
- R6: A difference that lies only in the `FRAC_W` fraction bits is enough to cause a step.
- R7: `delay_int` always equals the upper `INT_W` bits of `delay_full`. When `delay_full` passes its all-ones value it wraps to zero, and `delay_int` wraps with it.
- R8: If the target is moved N integer units away and the offsets are aligned to the step, the target is reached after exactly N·2^FRAC_W/UP_STEP ticks when rising (64·N by default) and N·2^FRAC_W/DN_STEP ticks when falling (128·N by default).
- R9: Each tick changes `delay_full` by one step at most: by `UP_STEP`, by `-DN_STEP`, or not at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-period strobe, one cycle wide |
| desired | input | INT_W+FRAC_W | Target delay, fixed point with FRAC_W fraction bits |
| delay_full | output | INT_W+FRAC_W | Current delay, full precision, registered |
| delay_int | output | INT_W | Integer part of the current delay, registered |

## Verification
The bench builds the block with `INT_W=4` and `FRAC_W=8`, which gives a 12-bit value with 4096 codes. At that size, a sweep of targets that alternate between the low and high ends of the range covers rise and fall distances up to almost full scale. Every tick is compared with an arithmetic step model, and the tick count of each move is compared with the distance divided by the step size. The narrow width also puts the overflow from all-ones to zero within about a thousand ticks, so the bench can check the wrap directly.

// File: rtl/dly_slew_pkg.sv
package dly_slew_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } slew_dir_e;
endpackage

// File: rtl/dly_slew_cmp.sv
module dly_slew_cmp
  import dly_slew_pkg::*;
#(
  parameter int W = 26
) (
  input  logic [W-1:0] actual,
  input  logic [W-1:0] target,
  output slew_dir_e    dir
);
  always_comb begin
    if (target > actual)      dir = DIR_UP;
    else if (target < actual) dir = DIR_DOWN;
    else                      dir = DIR_HOLD;
  end
endmodule

// File: rtl/dly_slew_step.sv
module dly_slew_step
  import dly_slew_pkg::*;
#(
  parameter int W       = 26,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 2
) (
  input  logic [W-1:0] cur,
  input  slew_dir_e    dir,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] UP_V = W'(UP_STEP);
  localparam logic [W-1:0] DN_V = W'(DN_STEP);

  // Width-limited sums wrap modulo 2^W, keeping the integer part in range.
  always_comb begin
    case (dir)
      DIR_UP:   nxt = cur + UP_V;
      DIR_DOWN: nxt = cur - DN_V;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/dly_slew_lim.sv
module dly_slew_lim
  import dly_slew_pkg::*;
#(
  parameter int INT_W   = 18,
  parameter int FRAC_W  = 8,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 2,
  parameter int RST_INT = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic [INT_W+FRAC_W-1:0]   desired,
  output logic [INT_W+FRAC_W-1:0]   delay_full,
  output logic [INT_W-1:0]          delay_int
);
  localparam int W = INT_W + FRAC_W;
  localparam logic [W-1:0]     RST_FULL = W'(RST_INT) << FRAC_W;
  localparam logic [INT_W-1:0] RST_IPART = INT_W'(RST_INT);

  slew_dir_e      dir;
  logic [W-1:0]   nxt;

  dly_slew_cmp #(.W(W)) cmp_i (
    .actual (delay_full),
    .target (desired),
    .dir    (dir)
  );

  dly_slew_step #(.W(W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) step_i (
    .cur (delay_full),
    .dir (dir),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_full <= RST_FULL;
      delay_int  <= RST_IPART;
    end else if (tick && dir != DIR_HOLD) begin
      delay_full <= nxt;
      delay_int  <= nxt[W-1:FRAC_W];
    end
  end
endmodule

// File: rtl/dly_slew_lim_chk.sv
module dly_slew_lim_chk #(
  parameter int INT_W   = 18,
  parameter int FRAC_W  = 8,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 2,
  parameter int RST_INT = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick,
  input logic [INT_W+FRAC_W-1:0] desired,
  input logic [INT_W+FRAC_W-1:0] delay_full,
  input logic [INT_W-1:0]        delay_int
);
  localparam int W = INT_W + FRAC_W;
  localparam logic [W-1:0] RST_FULL = W'(RST_INT) << FRAC_W;

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_value_r1: assert (delay_full == RST_FULL && delay_int == INT_W'(RST_INT))
        else $error("R1 reset value wrong");
    end
  end

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(delay_full) && $stable(delay_int)));

  p_hold_equal_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && desired == delay_full) |=> $stable(delay_full));

  p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && desired > delay_full) |=> delay_full == W'($past(delay_full) + W'(UP_STEP)));

  p_step_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && desired < delay_full) |=> delay_full == W'($past(delay_full) - W'(DN_STEP)));

  p_int_track_r7: assert property (@(posedge clk) disable iff (rst)
    delay_int == delay_full[W-1:FRAC_W]);

  p_one_step_r9: assert property (@(posedge clk) disable iff (rst)
    tick |=> (delay_full == $past(delay_full)
              || delay_full == W'($past(delay_full) + W'(UP_STEP))
              || delay_full == W'($past(delay_full) - W'(DN_STEP))));
endmodule

bind dly_slew_lim dly_slew_lim_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP), .RST_INT(RST_INT)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .desired    (desired),
  .delay_full (delay_full),
  .delay_int  (delay_int)
);

// File: tb/dly_slew_lim_tb_top.sv
module dly_slew_lim_tb_top;
  localparam int INT_W  = 4;
  localparam int FRAC_W = 8;
  localparam int UPS    = 4;
  localparam int DNS    = 2;
  localparam int W      = INT_W + FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [W-1:0] desired = '0;
  logic [W-1:0] delay_full;
  logic [INT_W-1:0] delay_int;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  dly_slew_lim #(.INT_W(INT_W), .FRAC_W(FRAC_W), .UP_STEP(UPS), .DN_STEP(DNS), .RST_INT(1)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .desired(desired),
    .delay_full(delay_full), .delay_int(delay_int)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One tick; the model steps by the requirement rules, then both outputs are compared.
  task automatic one_tick(input string req);
    @(negedge clk) tick = 1'b1;
    if (desired > model)      model = W'(model + W'(UPS));
    else if (desired < model) model = W'(model - W'(DNS));
    @(negedge clk) tick = 1'b0;
    check(delay_full == model, req, int'(delay_full), int'(model));
    check(delay_int == model[W-1:FRAC_W], "R7", int'(delay_int), int'(model[W-1:FRAC_W]));
  endtask

  // Move to a target and compare the tick count with distance / step (R8).
  task automatic glide(input logic [W-1:0] tgt);
    int exp_n;
    int n;
    exp_n = (tgt >= model) ? int'(tgt - model) / UPS : int'(model - tgt) / DNS;
    desired = tgt;
    n = 0;
    while (delay_full != tgt && n < 5000) begin
      one_tick((tgt > model) ? "R4" : "R5");
      n++;
    end
    check(n == exp_n, "R8", n, exp_n);
  endtask

  initial begin
    model = W'(1) << FRAC_W;
    repeat (3) @(negedge clk);
    check(delay_full == 12'h100, "R1", int'(delay_full), 'h100);
    rst = 1'b0;
    @(negedge clk);
    check(delay_full == 12'h100, "R1", int'(delay_full), 'h100);
    check(delay_int == 4'd1, "R1", int'(delay_int), 1);

    // R2: target far away, no tick
    desired = 12'h900;
    repeat (6) @(negedge clk);
    check(delay_full == 12'h100, "R2", int'(delay_full), 'h100);

    // R8 rise by 1 unit: 64 ticks; R3 hold at target
    glide(12'h200);
    check(delay_int == 4'd2, "R7", int'(delay_int), 2);
    for (int i = 0; i < 3; i++) one_tick("R3");
    check(delay_full == 12'h200, "R3", int'(delay_full), 'h200);

    // R8 fall by 1 unit: 128 ticks
    glide(12'h100);

    // R6: fraction-only differences
    desired = 12'h104;
    one_tick("R6");
    check(delay_full == 12'h104, "R6", int'(delay_full), 'h104);
    desired = 12'h102;
    one_tick("R6");
    check(delay_full == 12'h102, "R6", int'(delay_full), 'h102);
    glide(12'h100);

    // Alternating sweep across the range
    for (int k = 0; k < 16; k++) begin
      glide((k % 2 == 1) ? W'(12'hF00 - k * 'h40) : W'(k * 'h40));
    end

    // R7 wrap at all-ones
    glide(12'hFF8);
    desired = 12'hFFF;
    one_tick("R4");
    check(delay_full == 12'hFFC, "R4", int'(delay_full), 'hFFC);
    one_tick("R7");
    check(delay_full == 12'h000, "R7", int'(delay_full), 0);
    check(delay_int == 4'd0, "R7", int'(delay_int), 0);
    one_tick("R9");
    check(delay_full == 12'h004, "R9", int'(delay_full), 4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule